// File: doc/BRIEF.md
# Triggered One-Shot Pulse Timer

This block is a 16-bit timer that produces exactly one output pulse for each accepted trigger. Once it is enabled, the timer arms itself and waits. A trigger can come from a selected edge of a pin-level input, after that input passes through a synchronizer, or from a one-cycle software strobe. When a trigger is accepted, the counter restarts from zero. The output goes active after a programmable number of count ticks and stays active for a programmable span. The counter then clears, stops and waits for the next trigger.

Two compare values set the timing. `cmp_delay` sets the tick at which the output turns on. `cmp_end` sets the tick after which it turns off, so the active width is `cmp_end - cmp_delay + 1` ticks. Each value has its own one-cycle strobe, raised when the count reaches it. Both compare values are captured into buffer registers whenever no pulse is running. Software can therefore reprogram the next pulse while the current one completes undisturbed. The counter only moves on cycles where the `tick` input is high, so an external prescaler sets the time base.

The controller is a three-state machine:
- **OFF**: enable low.
- **ARMED**: waiting for a trigger.
- **RUN**: counting.

Its transitions are:
- **arm**: OFF to ARMED, when enable is seen high; the counter is parked at all ones.
- **fire**: ARMED to RUN, on an accepted trigger; the counter is set to zero.
- **finish**: RUN to ARMED, on the tick where the count equals the end compare; the counter is cleared to zero and the output drops.
- **kill**: any state to OFF, when enable is low; the output and strobes are forced low.

Top module: `oneshot_timer`

## Requirements
- R1: After reset, and for as long as `enable` is low, `pulse_out`, `irq_delay` and `irq_end` are 0, and no trigger of either kind starts a pulse.
- R2: A trigger is accepted while armed from two sources. The first is `sw_trig` sampled high at a clock edge. The second is an edge of `trig_in`, taken through a 2-stage synchronizer and accepted at the third rising clock edge after the input changes. `edge_sel` picks the edge: 2'b00 rising, 2'b01 falling, 2'b10 both, 2'b11 none.
- R3: `pulse_out` rises at the clock edge of the `cmp_delay`-th tick after the accepting edge, or at the accepting edge itself when `cmp_delay` is 0. `irq_delay` is high for exactly that one cycle.
- R4: With `cmp_delay <= cmp_end`, `pulse_out` stays high for exactly `cmp_end - cmp_delay + 1` ticks. These are counted as ticks sampled at clock edges from the edge after the rise through the edge at which it falls.
- R5: `irq_end` is a one-cycle strobe raised when the count reaches `cmp_end`. It occurs during every pulse, no later than the cycle before `pulse_out` falls.
- R6: A trigger of either kind that arrives while a pulse sequence is running is ignored: no second `irq_delay` and no stretch of the pulse.
- R7: Compare values written while a sequence runs do not affect it. The values in force are those present at the accepting edge.
- R8: When `enable` is sampled low, `pulse_out` and both strobes are 0 from the next cycle on. The machine returns to OFF, and a later enable re-arms it.
- R9: While a sequence runs, a cycle with `tick` low changes neither the count, nor `pulse_out`, nor either strobe.
- R10: When armed from OFF, the counter holds all ones. After a completed pulse it holds zero. In both cases an accepted trigger restarts counting from zero, so the delay is the same.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count-enable strobe; the counter moves only when high |
| enable | input | 1 | Timer enable; low forces OFF |
| trig_in | input | 1 | Asynchronous external trigger input |
| edge_sel | input | 2 | External edge choice: 00 rising, 01 falling, 10 both, 11 none |
| sw_trig | input | 1 | Software trigger, one-cycle strobe |
| cmp_end | input | 16 | End compare value (pulse turns off after this count) |
| cmp_delay | input | 16 | Delay compare value (pulse turns on at this count) |
| pulse_out | output | 1 | One-shot pulse output, active high |
| irq_end | output | 1 | One-cycle strobe when the count reaches `cmp_end` |
| irq_delay | output | 1 | One-cycle strobe when the count reaches `cmp_delay` |

## Verification
The properties assume that `trig_in` is low when reset is released, so the synchronizer does not report a false edge. They also assume the delay compare never exceeds the end compare, because otherwise the end strobe precedes a pulse that never comes. The stimulus holds `trig_in` at 0 through reset, programs only ordered compare pairs, and keeps each level of `trig_in` for several cycles so that every intended edge crosses the synchronizer. Software triggers are always single-cycle strobes driven on the falling clock edge. Retriggers and enable drops are placed deliberately inside the delay and active phases.

// File: rtl/ost_pkg.sv
package ost_pkg;

    typedef enum logic [1:0] {
        ST_OFF   = 2'b00,
        ST_ARMED = 2'b01,
        ST_RUN   = 2'b10
    } ost_state_e;

    typedef enum logic [1:0] {
        EDGE_RISE = 2'b00,
        EDGE_FALL = 2'b01,
        EDGE_BOTH = 2'b10,
        EDGE_NONE = 2'b11
    } ost_edge_e;

endpackage

// File: rtl/ost_trig_detect.sv
module ost_trig_detect #(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       trig_in,
    input  logic [1:0] edge_sel,
    input  logic       sw_trig,
    output logic       trig_evt
);
    import ost_pkg::*;

    localparam int LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   rise, fall, ext_evt;
    ost_edge_e              sel;

    // synchronizer chain followed by one history flop
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], trig_in};
            prev_q <= sync_q[LAST];
        end
    end

    assign sel  = ost_edge_e'(edge_sel);
    assign rise = sync_q[LAST] & ~prev_q;
    assign fall = ~sync_q[LAST] & prev_q;

    always_comb begin
        ext_evt = 1'b0;
        unique case (sel)
            EDGE_RISE: ext_evt = rise;
            EDGE_FALL: ext_evt = fall;
            EDGE_BOTH: ext_evt = rise | fall;
            EDGE_NONE: ext_evt = 1'b0;
        endcase
    end

    assign trig_evt = ext_evt | sw_trig;

endmodule

// File: rtl/ost_cmp_buf.sv
module ost_cmp_buf #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    // shadow copy, refreshed only while no sequence runs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            dout <= '0;
        else if (load)
            dout <= din;
    end

endmodule

// File: rtl/oneshot_timer.sv
module oneshot_timer #(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             enable,
    input  logic             trig_in,
    input  logic [1:0]       edge_sel,
    input  logic             sw_trig,
    input  logic [CNT_W-1:0] cmp_end,
    input  logic [CNT_W-1:0] cmp_delay,
    output logic             pulse_out,
    output logic             irq_end,
    output logic             irq_delay
);
    import ost_pkg::*;

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    ost_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc;
    logic [CNT_W-1:0] end_buf, dly_buf;
    logic             trig_evt, buf_load;
    logic             hit_dly, hit_end, finish;

    ost_trig_detect #(.SYNC_STAGES(SYNC_STAGES)) u_trig (
        .clk      (clk),
        .rst_n    (rst_n),
        .trig_in  (trig_in),
        .edge_sel (edge_sel),
        .sw_trig  (sw_trig),
        .trig_evt (trig_evt)
    );

    assign buf_load = (state_q != ST_RUN);

    ost_cmp_buf #(.WIDTH(CNT_W)) u_end_buf (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (buf_load),
        .din   (cmp_end),
        .dout  (end_buf)
    );

    ost_cmp_buf #(.WIDTH(CNT_W)) u_dly_buf (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (buf_load),
        .din   (cmp_delay),
        .dout  (dly_buf)
    );

    assign cnt_inc = cnt_q + CNT_ONE;

    // next-state, counter and compare events
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        hit_dly = 1'b0;
        hit_end = 1'b0;
        finish  = 1'b0;
        if (!enable) begin
            state_d = ST_OFF;                       // kill
        end else begin
            unique case (state_q)
                ST_OFF: begin                       // arm
                    state_d = ST_ARMED;
                    cnt_d   = '1;
                end
                ST_ARMED: begin
                    if (trig_evt) begin             // fire
                        state_d = ST_RUN;
                        cnt_d   = '0;
                        hit_dly = (cmp_delay == '0);
                        hit_end = (cmp_end == '0);
                    end
                end
                ST_RUN: begin
                    if (tick) begin
                        if (cnt_q == end_buf) begin // finish
                            finish  = 1'b1;
                            state_d = ST_ARMED;
                            cnt_d   = '0;
                        end else begin
                            cnt_d   = cnt_inc;
                            hit_dly = (cnt_inc == dly_buf);
                            hit_end = (cnt_inc == end_buf);
                        end
                    end
                end
                default: state_d = ST_OFF;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            cnt_q   <= '1;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pulse_out <= 1'b0;
            irq_delay <= 1'b0;
            irq_end   <= 1'b0;
        end else if (!enable) begin
            pulse_out <= 1'b0;
            irq_delay <= 1'b0;
            irq_end   <= 1'b0;
        end else begin
            if (finish)
                pulse_out <= 1'b0;
            else if (hit_dly)
                pulse_out <= 1'b1;
            irq_delay <= hit_dly;
            irq_end   <= hit_end;
        end
    end

endmodule

// File: rtl/ost_checker.sv
module ost_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             enable,
    input logic             busy,
    input logic [CNT_W-1:0] cnt,
    input logic             pulse_out,
    input logic             irq_delay,
    input logic             irq_end
);
    logic end_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            end_seen <= 1'b0;
        else
            end_seen <= irq_end | (end_seen & pulse_out);
    end

    a_r8_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!pulse_out && !irq_delay && !irq_end));

    a_r3_rise_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse_out) |-> irq_delay);

    a_r5_fall_after_end: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pulse_out) |-> (end_seen || !$past(enable)));

    a_r5_end_single: assert property (@(posedge clk) disable iff (!rst_n)
        irq_end |=> !irq_end);

    a_r6_no_retrigger: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_out |=> !irq_delay);

    a_r9_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && enable && !tick) |=> ($stable(pulse_out) && $stable(cnt) && !irq_delay && !irq_end));

    a_r10_park_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(enable) |=> (cnt == '1));

    a_r1_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && !$past(enable)) |-> (!pulse_out && !irq_delay && !irq_end));

endmodule

bind oneshot_timer ost_checker #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .enable    (enable),
    .busy      (state_q == ost_pkg::ST_RUN),
    .cnt       (cnt_q),
    .pulse_out (pulse_out),
    .irq_delay (irq_delay),
    .irq_end   (irq_end)
);

// File: tb/oneshot_timer_tb.sv
`timescale 1ns/1ps
module oneshot_timer_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b1;
    logic        enable = 1'b0;
    logic        trig_in = 1'b0;
    logic [1:0]  edge_sel = 2'b00;
    logic        sw_trig = 1'b0;
    logic [15:0] cmp_end = '0;
    logic [15:0] cmp_delay = '0;
    logic        pulse_out, irq_end, irq_delay;

    int  checks = 0;
    int  fails = 0;
    int  tick_div = 1;
    int  cyc = 0;
    int  phase = 0;
    bit  mon_on = 1'b1;
    bit  acc_mark = 1'b0;
    bit  done = 1'b0;

    typedef struct { int dly; int wid; } exp_t;
    exp_t sb_q[$];

    always #2 clk = ~clk;

    oneshot_timer u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .enable(enable),
        .trig_in(trig_in), .edge_sel(edge_sel), .sw_trig(sw_trig),
        .cmp_end(cmp_end), .cmp_delay(cmp_delay),
        .pulse_out(pulse_out), .irq_end(irq_end), .irq_delay(irq_delay)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    // tick generator
    initial forever begin
        @(negedge clk);
        cyc++;
        tick = (tick_div <= 1) ? 1'b1 : ((cyc % tick_div) == 0);
    end

    // monitor: pops expected items and measures delay and width in ticks
    initial begin
        exp_t cur;
        int   tcnt, wcnt;
        bit   end_flag;
        cur = '{0, 0}; tcnt = 0; wcnt = 0; end_flag = 1'b0;
        forever begin
            @(posedge clk); #1;
            if (!rst_n || !mon_on) begin
                phase = 0;
            end else if (phase == 0) begin
                if (acc_mark) begin
                    if (sb_q.size() == 0) begin
                        chk(1'b0, "R2", "accept without expected item", 1, 0);
                        cur = '{0, 1};
                    end else begin
                        cur = sb_q.pop_front();
                    end
                    tcnt = 0; wcnt = 0; end_flag = irq_end;
                    if (pulse_out) begin
                        chk(irq_delay, "R3", "irq_delay at zero-delay rise", irq_delay, 1);
                        chk(cur.dly == 0, "R3", "delay ticks", 0, cur.dly);
                        phase = 2;
                    end else begin
                        phase = 1;
                    end
                end else if (pulse_out || irq_delay || irq_end) begin
                    chk(1'b0, "R6", "activity without an accepted trigger", 1, 0);
                end
            end else if (phase == 1) begin
                if (tick) tcnt++;
                if (irq_end) end_flag = 1'b1;
                if (pulse_out) begin
                    chk(irq_delay, "R3", "irq_delay at rise", irq_delay, 1);
                    chk(tcnt == cur.dly, "R3", "delay ticks", tcnt, cur.dly);
                    phase = 2; wcnt = 0;
                end else if (irq_delay) begin
                    chk(1'b0, "R3", "irq_delay without rise", 1, 0);
                end
            end else begin
                if (tick) wcnt++;
                if (irq_delay) chk(1'b0, "R6", "second irq_delay in pulse", 1, 0);
                if (!pulse_out) begin
                    chk(wcnt == cur.wid, "R4", "width ticks", wcnt, cur.wid);
                    chk(end_flag, "R5", "irq_end seen before fall", end_flag, 1);
                    phase = 0;
                end else if (irq_end) begin
                    end_flag = 1'b1;
                end
            end
        end
    end

    task automatic sw_pulse(input int d1, input int d0, input bit expect_acc);
        @(negedge clk);
        cmp_delay = 16'(d1); cmp_end = 16'(d0);
        sw_trig = 1'b1; acc_mark = expect_acc;
        if (expect_acc) sb_q.push_back('{d1, d0 - d1 + 1});
        @(negedge clk);
        sw_trig = 1'b0; acc_mark = 1'b0;
    endtask

    task automatic poke_sw();
        @(negedge clk); sw_trig = 1'b1;
        @(negedge clk); sw_trig = 1'b0;
    endtask

    task automatic ext_fire(input bit lvl, input bit expect_acc, input int d1, input int d0);
        @(negedge clk);
        cmp_delay = 16'(d1); cmp_end = 16'(d0);
        trig_in = lvl;
        @(negedge clk);
        @(negedge clk);
        acc_mark = expect_acc;
        if (expect_acc) sb_q.push_back('{d1, d0 - d1 + 1});
        @(negedge clk);
        acc_mark = 1'b0;
    endtask

    task automatic wait_idle(input string req);
        int n;
        n = 0;
        @(negedge clk);
        while (!(sb_q.size() == 0 && phase == 0) && n < 3000) begin
            @(negedge clk); n++;
        end
        if (n >= 3000) begin
            chk(1'b0, req, "pulse sequence did not complete", phase, 0);
            sb_q.delete();
            mon_on = 1'b0; @(negedge clk); @(negedge clk); mon_on = 1'b1;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic expect_quiet(input int cycles, input string req);
        for (int i = 0; i < cycles; i++) @(negedge clk);
        chk(pulse_out == 1'b0, req, "pulse_out stays low", pulse_out, 0);
    endtask

    initial begin
        #400000;
        chk(1'b0, "R1", "watchdog expired", 1, 0);
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(pulse_out == 1'b0, "R1", "pulse_out after reset", pulse_out, 0);
        chk(irq_delay == 1'b0, "R1", "irq_delay after reset", irq_delay, 0);
        chk(irq_end == 1'b0, "R1", "irq_end after reset", irq_end, 0);

        // R1: triggers ignored while disabled
        sw_pulse(0, 3, 1'b0);
        ext_fire(1'b1, 1'b0, 0, 3);
        expect_quiet(8, "R1");
        trig_in = 1'b0;
        repeat (4) @(negedge clk);

        enable = 1'b1;
        repeat (3) @(negedge clk);

        // R2 R3 R4 R5: software trigger, tick every cycle
        sw_pulse(3, 7, 1'b1);  wait_idle("R3");
        // R3 R4: zero delay, single-tick width
        sw_pulse(0, 0, 1'b1);  wait_idle("R3");
        // R4: equal compares give width 1
        sw_pulse(5, 5, 1'b1);  wait_idle("R4");

        // R9: sparse ticks
        tick_div = 3;
        repeat (3) @(negedge clk);
        sw_pulse(2, 4, 1'b1);  wait_idle("R9");
        tick_div = 4;
        sw_pulse(0, 3, 1'b1);  wait_idle("R9");
        tick_div = 1;
        repeat (3) @(negedge clk);

        // R6: retriggers during delay and active phases are ignored
        sw_pulse(4, 9, 1'b1);
        poke_sw();
        repeat (4) @(negedge clk);
        poke_sw();
        wait_idle("R6");
        expect_quiet(12, "R6");

        // R7: compare writes mid-pulse do not disturb the running pulse
        sw_pulse(3, 10, 1'b1);
        repeat (2) @(negedge clk);
        cmp_delay = 16'd1; cmp_end = 16'd2;
        wait_idle("R7");
        sw_pulse(1, 2, 1'b1);  wait_idle("R7");

        // R2: external trigger, rising edge select
        edge_sel = 2'b00;
        ext_fire(1'b1, 1'b1, 2, 3);  wait_idle("R2");
        ext_fire(1'b0, 1'b0, 2, 3);  expect_quiet(10, "R2");
        // falling edge select
        edge_sel = 2'b01;
        ext_fire(1'b1, 1'b0, 1, 2);  expect_quiet(10, "R2");
        ext_fire(1'b0, 1'b1, 1, 2);  wait_idle("R2");
        // both edges
        edge_sel = 2'b10;
        ext_fire(1'b1, 1'b1, 0, 1);  wait_idle("R2");
        ext_fire(1'b0, 1'b1, 2, 2);  wait_idle("R2");
        // none
        edge_sel = 2'b11;
        ext_fire(1'b1, 1'b0, 0, 1);
        ext_fire(1'b0, 1'b0, 0, 1);
        expect_quiet(10, "R2");
        // R6: external edge during a running pulse is ignored
        edge_sel = 2'b00;
        sw_pulse(5, 12, 1'b1);
        ext_fire(1'b1, 1'b0, 5, 12);
        wait_idle("R6");
        trig_in = 1'b0;
        repeat (5) @(negedge clk);

        // R8: enable drop mid-pulse
        mon_on = 1'b0;
        cmp_delay = 16'd2; cmp_end = 16'd40;
        poke_sw();
        repeat (6) @(negedge clk);
        chk(pulse_out == 1'b1, "R8", "pulse active before enable drop", pulse_out, 1);
        enable = 1'b0;
        @(negedge clk);
        chk(pulse_out == 1'b0, "R8", "pulse_out cleared after enable drop", pulse_out, 0);
        poke_sw();
        expect_quiet(6, "R8");
        enable = 1'b1;
        repeat (3) @(negedge clk);
        mon_on = 1'b1;
        @(negedge clk);

        // R10: from the all-ones park, then from zero after a pulse
        sw_pulse(6, 8, 1'b1);  wait_idle("R10");
        sw_pulse(6, 8, 1'b1);  wait_idle("R10");

        repeat (5) @(negedge clk);
        finish_run();
    end

endmodule